// File: doc/BRIEF.md
# PIPE Link Rate Switch Controller

This block runs the speed change of one PCIe lane on a PIPE interface that stays 32 bits wide at every speed. The three speeds are 2.5, 5 and 8 Gbps. The fabric strobes in a 2-bit rate code. The controller compares it with the rate currently applied. When the two differ, it raises a level switch request toward the PMA and holds it until the PMA returns switch-done. The controller then moves its clock-divider selects and its PCS path select to the new rate, and gives the fabric a one-cycle PHY status pulse.

The only clocking the block does is through select outputs. At the lowest speed it enables an extra halving stage on the PCIe PLL clock. It picks a fabric-clock divide ratio so that the fabric runs at 62.5, 125 or 250 MHz while the width stays fixed. It steers the datapath to the 128b/130b PCS only at the highest speed, and to the 8b/10b PCS otherwise. A sticky error flag records two events: a request for the unused rate code, and a PMA that never answers within a timeout count the fabric programs.

Top module: `pipe_rate_switch_ctrl`

## Requirements
- R1: After reset the applied rate is code 2'b00 (2.5 Gbps), and switch request, PHY status and error are all low. The applied rate never shows 2'b11.
- R2: The divider selects follow the applied rate. Code 2'b00 sets `pll_div2_en_o`=1 and `fab_div_log2_o`=2. Code 2'b01 sets 0 and 2. Code 2'b10 sets 0 and 0.
- R3: `gen3_pcs_sel_o` is 1 only while the applied rate is 2'b10. It is 0 for 2'b00 and 2'b01.
- R4: A request for a legal rate other than the applied one raises `pma_sw_req_o` exactly once and holds it until switch-done is sampled. The applied rate then changes, and exactly one single-cycle PHY status pulse follows. Status and switch request are never high together.
- R5: A request for the rate already applied produces one PHY status pulse and no switch request.
- R6: A request with code 2'b11 is ignored. It causes no switch request and no status pulse, and it leaves the applied rate unchanged. It sets `rate_err_o`, which stays set until reset.
- R7: A request that arrives while a switch is in progress is held and serviced after the controller returns to idle. If several arrive, the latest one wins.
- R8: The controller samples switch-done on the first `tmo_limit_i`+2 rising edges after the edge that raised the switch request. If switch-done is not seen by then, the switch is aborted. The switch request drops, the applied rate and all selects stay at the previous rate, no status pulse is given, and `rate_err_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rate_req_vld_i | input | 1 | One-cycle strobe: new rate request |
| rate_req_i | input | 2 | Requested rate code (00, 01, 10; 11 unused) |
| tmo_limit_i | input | TMO_W | Timeout count for switch-done |
| pma_sw_req_o | output | 1 | Switch request to the PMA (level) |
| pma_sw_done_i | input | 1 | Switch-done acknowledge from the PMA |
| phy_status_o | output | 1 | One-cycle completion pulse to the fabric |
| cur_rate_o | output | 2 | Currently applied rate code |
| gen3_pcs_sel_o | output | 1 | 1 selects the 128b/130b PCS path |
| pll_div2_en_o | output | 1 | Enables the extra halving of the PLL clock |
| fab_div_log2_o | output | 2 | log2 of the fabric-clock divide ratio |
| rate_err_o | output | 1 | Sticky error: unused code or timeout |

## Verification
The bench aims at the edge of the timeout window. A PMA that answers on the last allowed edge must complete the switch, and one that answers a single edge later must abort. An off-by-one counter passes one of these and fails the other. Same-rate requests check that no handshake is started but a status pulse still appears; a design that skipped the pulse would leave the fabric waiting. Requests strobed during an ongoing switch check that none is lost and that the newest one is the one applied; a controller that dropped them would stop at the wrong rate. Reserved codes and aborts check that the rate and all dividers stay where they were while the sticky error rises.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

    typedef enum logic [1:0] {
        RATE_G1  = 2'b00,
        RATE_G2  = 2'b01,
        RATE_G3  = 2'b10,
        RATE_RSV = 2'b11
    } rate_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_UPDATE,
        ST_STATUS
    } seq_st_e;

    localparam int NUM_RATES     = 3;
    localparam int FAB_LOG2_W    = 2;
    localparam int FAB_LOG2_SLOW = 2;
    localparam int FAB_LOG2_FAST = 0;

    typedef struct packed {
        logic                  pll_div2_en;
        logic [FAB_LOG2_W-1:0] fab_div_log2;
        logic                  gen3_pcs_sel;
    } clk_plan_t;

    function automatic clk_plan_t plan_for(rate_e r);
        clk_plan_t p;
        p = '0;
        case (r)
            RATE_G1: begin
                p.pll_div2_en  = 1'b1;
                p.fab_div_log2 = FAB_LOG2_W'(FAB_LOG2_SLOW);
            end
            RATE_G2: begin
                p.fab_div_log2 = FAB_LOG2_W'(FAB_LOG2_SLOW);
            end
            RATE_G3: begin
                p.fab_div_log2 = FAB_LOG2_W'(FAB_LOG2_FAST);
                p.gen3_pcs_sel = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rsw_req_hold.sv
module rsw_req_hold
    import rsw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       vld_i,
    input  logic [1:0] rate_i,
    input  logic       take_i,
    output logic       pend_o,
    output logic [1:0] pend_rate_o,
    output logic       rsv_hit_o
);

    typedef struct packed {
        logic       pend;
        logic [1:0] rate;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  legal;

    always_comb begin
        legal     = (rate_i != RATE_RSV);
        rsv_hit_o = vld_i && !legal;
        hold_d    = hold_q;
        if (take_i) begin
            hold_d.pend = 1'b0;
        end
        // A fresh legal request overwrites any older one still waiting.
        if (vld_i && legal) begin
            hold_d.pend = 1'b1;
            hold_d.rate = rate_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign pend_o      = hold_q.pend;
    assign pend_rate_o = hold_q.rate;

endmodule

// File: rtl/rsw_seq_fsm.sv
module rsw_seq_fsm
    import rsw_pkg::*;
#(
    parameter int         TMO_W      = 16,
    parameter logic [1:0] RESET_RATE = 2'b00
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pend_i,
    input  logic [1:0]       pend_rate_i,
    input  logic             rsv_hit_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             sw_done_i,
    output logic             take_o,
    output logic             sw_req_o,
    output logic             status_o,
    output logic [1:0]       cur_rate_o,
    output logic             err_o
);

    typedef struct packed {
        seq_st_e          st;
        logic [1:0]       cur;
        logic [1:0]       tgt;
        logic [TMO_W-1:0] cnt;
        logic             err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        take_o = 1'b0;
        if (rsv_hit_i) begin
            seq_d.err = 1'b1;
        end
        case (seq_q.st)
            ST_IDLE: begin
                if (pend_i) begin
                    take_o = 1'b1;
                    if (pend_rate_i == seq_q.cur) begin
                        seq_d.st = ST_STATUS;
                    end else begin
                        seq_d.tgt = pend_rate_i;
                        seq_d.st  = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                seq_d.cnt = '0;
                seq_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (sw_done_i) begin
                    seq_d.st = ST_UPDATE;
                end else if (seq_q.cnt == tmo_limit_i) begin
                    // Abort: keep the previous rate, flag the failure.
                    seq_d.st  = ST_IDLE;
                    seq_d.tgt = seq_q.cur;
                    seq_d.err = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_UPDATE: begin
                seq_d.cur = seq_q.tgt;
                seq_d.st  = ST_STATUS;
            end
            ST_STATUS: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q     <= '0;
            seq_q.st  <= ST_IDLE;
            seq_q.cur <= RESET_RATE;
            seq_q.tgt <= RESET_RATE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sw_req_o   = (seq_q.st == ST_REQ) || (seq_q.st == ST_WAIT);
    assign status_o   = (seq_q.st == ST_STATUS);
    assign cur_rate_o = seq_q.cur;
    assign err_o      = seq_q.err;

endmodule

// File: rtl/rsw_clk_plan.sv
module rsw_clk_plan
    import rsw_pkg::*;
(
    input  logic                  rate_i,
    input  logic [1:0]            rate_code_i,
    output logic                  pll_div2_en_o,
    output logic [FAB_LOG2_W-1:0] fab_div_log2_o,
    output logic                  gen3_pcs_sel_o
);

    logic [NUM_RATES-1:0] hit;
    clk_plan_t            plan;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_hit
        assign hit[g] = rate_i && (rate_code_i == 2'(g));
    end

    always_comb begin
        plan = '0;
        for (int k = 0; k < NUM_RATES; k++) begin
            if (hit[k]) begin
                plan = plan | plan_for(rate_e'(2'(k)));
            end
        end
    end

    assign pll_div2_en_o  = plan.pll_div2_en;
    assign fab_div_log2_o = plan.fab_div_log2;
    assign gen3_pcs_sel_o = plan.gen3_pcs_sel;

endmodule

// File: rtl/pipe_rate_switch_ctrl.sv
module pipe_rate_switch_ctrl
    import rsw_pkg::*;
#(
    parameter int         TMO_W      = 16,
    parameter logic [1:0] RESET_RATE = 2'b00
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rate_req_vld_i,
    input  logic [1:0]       rate_req_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    output logic             pma_sw_req_o,
    input  logic             pma_sw_done_i,
    output logic             phy_status_o,
    output logic [1:0]       cur_rate_o,
    output logic             gen3_pcs_sel_o,
    output logic             pll_div2_en_o,
    output logic [1:0]       fab_div_log2_o,
    output logic             rate_err_o
);

    logic       pend;
    logic [1:0] pend_rate;
    logic       rsv_hit;
    logic       take;
    logic [1:0] cur_rate;

    rsw_req_hold u_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .vld_i       (rate_req_vld_i),
        .rate_i      (rate_req_i),
        .take_i      (take),
        .pend_o      (pend),
        .pend_rate_o (pend_rate),
        .rsv_hit_o   (rsv_hit)
    );

    rsw_seq_fsm #(
        .TMO_W      (TMO_W),
        .RESET_RATE (RESET_RATE)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pend_i      (pend),
        .pend_rate_i (pend_rate),
        .rsv_hit_i   (rsv_hit),
        .tmo_limit_i (tmo_limit_i),
        .sw_done_i   (pma_sw_done_i),
        .take_o      (take),
        .sw_req_o    (pma_sw_req_o),
        .status_o    (phy_status_o),
        .cur_rate_o  (cur_rate),
        .err_o       (rate_err_o)
    );

    rsw_clk_plan u_plan (
        .rate_i         (1'b1),
        .rate_code_i    (cur_rate),
        .pll_div2_en_o  (pll_div2_en_o),
        .fab_div_log2_o (fab_div_log2_o),
        .gen3_pcs_sel_o (gen3_pcs_sel_o)
    );

    assign cur_rate_o = cur_rate;

endmodule

// File: rtl/rsw_chk.sv
module rsw_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       rate_req_vld_i,
    input logic [1:0] rate_req_i,
    input logic       pma_sw_req_o,
    input logic       phy_status_o,
    input logic [1:0] cur_rate_o,
    input logic       gen3_pcs_sel_o,
    input logic       rate_err_o
);

    a_r1_rate_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_rate_o != 2'b11);

    a_r3_gen3_path_only_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen3_pcs_sel_o |-> (cur_rate_o == 2'b10));

    a_r4_status_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phy_status_o |=> !phy_status_o);

    a_r4_status_req_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(phy_status_o && pma_sw_req_o));

    a_r4_rate_moves_with_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cur_rate_o) |-> phy_status_o);

    a_r8_rate_frozen_in_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pma_sw_req_o |=> $stable(cur_rate_o));

    a_r6_reserved_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_req_vld_i && rate_req_i == 2'b11) |=> rate_err_o);

    a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rate_err_o |=> rate_err_o);

endmodule

bind pipe_rate_switch_ctrl rsw_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rate_req_vld_i (rate_req_vld_i),
    .rate_req_i     (rate_req_i),
    .pma_sw_req_o   (pma_sw_req_o),
    .phy_status_o   (phy_status_o),
    .cur_rate_o     (cur_rate_o),
    .gen3_pcs_sel_o (gen3_pcs_sel_o),
    .rate_err_o     (rate_err_o)
);

// File: tb/tb_pipe_rate_switch_ctrl.sv
module tb_pipe_rate_switch_ctrl;

    localparam int TMO_W  = 16;
    localparam int LIM    = 20;
    localparam int OP_CYC = LIM + 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vld = 1'b0;
    logic [1:0]       rate = 2'b00;
    logic [TMO_W-1:0] tmo = TMO_W'(LIM);
    logic             sw_req;
    logic             sw_done = 1'b0;
    logic             status;
    logic [1:0]       cur;
    logic             g3sel;
    logic             div2;
    logic [1:0]       fabdiv;
    logic             err;

    int total = 0;
    int bad = 0;
    int done_delay = 1;
    int seen = 0;
    int n_status = 0;
    int n_rise = 0;
    logic prev_req = 1'b0;
    logic [1:0] exp_cur = 2'b00;
    logic exp_err = 1'b0;

    always #4 clk = ~clk;

    pipe_rate_switch_ctrl #(.TMO_W(TMO_W)) dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .rate_req_vld_i (vld),
        .rate_req_i     (rate),
        .tmo_limit_i    (tmo),
        .pma_sw_req_o   (sw_req),
        .pma_sw_done_i  (sw_done),
        .phy_status_o   (status),
        .cur_rate_o     (cur),
        .gen3_pcs_sel_o (g3sel),
        .pll_div2_en_o  (div2),
        .fab_div_log2_o (fabdiv),
        .rate_err_o     (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int exp_div2(input logic [1:0] r);
        return (r == 2'b00) ? 1 : 0;
    endfunction

    function automatic int exp_fab(input logic [1:0] r);
        return (r == 2'b10) ? 0 : 2;
    endfunction

    function automatic int exp_g3(input logic [1:0] r);
        return (r == 2'b10) ? 1 : 0;
    endfunction

    // One negedge: PMA model plus output monitors.
    task automatic step();
        @(negedge clk);
        if (sw_req) begin
            seen++;
            sw_done = (seen >= done_delay);
        end else begin
            seen = 0;
            sw_done = 1'b0;
        end
        if (sw_req && !prev_req) n_rise++;
        prev_req = sw_req;
        if (status) n_status++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_req(input logic [1:0] r);
        step();
        rate = r;
        vld  = 1'b1;
        step();
        vld  = 1'b0;
    endtask

    task automatic check_state(input string tag);
        chk(cur == exp_cur, tag, cur, exp_cur);
        chk(int'(div2) == exp_div2(exp_cur), "R2 div2", div2, exp_div2(exp_cur));
        chk(int'(fabdiv) == exp_fab(exp_cur), "R2 fabdiv", fabdiv, exp_fab(exp_cur));
        chk(int'(g3sel) == exp_g3(exp_cur), "R3 pcs_sel", g3sel, exp_g3(exp_cur));
        chk(err == exp_err, "R6 err", err, exp_err);
        chk(sw_req == 1'b0, "R4 req_idle", sw_req, 0);
    endtask

    task automatic do_op(input logic [1:0] r, input int d, input string tag);
        done_delay = d;
        n_status = 0;
        n_rise = 0;
        pulse_req(r);
        run(OP_CYC);
        if (r == 2'b11) begin
            exp_err = 1'b1;
            chk(n_status == 0, "R6 no_status", n_status, 0);
            chk(n_rise == 0, "R6 no_req", n_rise, 0);
        end else if (d > LIM + 2) begin
            exp_err = 1'b1;
            chk(n_status == 0, "R8 no_status", n_status, 0);
            chk(n_rise == 1, "R8 one_req", n_rise, 1);
        end else begin
            chk(n_status == 1, (r == exp_cur) ? "R5 status" : "R4 status", n_status, 1);
            chk(n_rise == int'(r != exp_cur), (r == exp_cur) ? "R5 no_req" : "R4 one_req",
                n_rise, int'(r != exp_cur));
            exp_cur = r;
        end
        check_state(tag);
    endtask

    task automatic hold_op(input logic [1:0] a, input logic [1:0] b,
                           input logic [1:0] c, input bit three);
        logic [1:0] fin;
        int exp_r;
        fin = three ? c : b;
        exp_r = int'(a != exp_cur) + int'(fin != a);
        done_delay = 5;
        n_status = 0;
        n_rise = 0;
        pulse_req(a);
        run(2);
        pulse_req(b);
        if (three) begin
            run(1);
            pulse_req(c);
        end
        run(100);
        chk(n_status == 2, "R7 status_count", n_status, 2);
        chk(n_rise == exp_r, "R7 handshakes", n_rise, exp_r);
        exp_cur = fin;
        check_state("R7 final_rate");
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        vld = 1'b0;
        run(3);
        rst_n = 1'b1;
        exp_cur = 2'b00;
        exp_err = 1'b0;
        step();
        chk(status == 1'b0, "R1 status_low", status, 0);
        check_state("R1 reset_rate");
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        apply_reset();

        // Directed: every rate, then same-rate requests.
        do_op(2'b01, 3, "R4 to_g2");
        do_op(2'b10, 4, "R4 to_g3");
        do_op(2'b10, 2, "R5 same_g3");
        do_op(2'b00, 1, "R4 to_g1");
        do_op(2'b00, 6, "R5 same_g1");

        // Random legal switches with answer delays inside the window.
        for (int i = 0; i < 50; i++) begin
            logic [1:0] r;
            int d;
            r = 2'($urandom % 3);
            d = 1 + int'($urandom % (LIM + 2));
            do_op(r, d, "R4 random");
        end

        // Requests during a switch: held, latest wins.
        hold_op((exp_cur == 2'b10) ? 2'b00 : 2'b10, 2'b01, 2'b00, 1'b1);
        for (int i = 0; i < 10; i++) begin
            logic [1:0] a;
            logic [1:0] b;
            a = 2'($urandom % 3);
            b = 2'($urandom % 3);
            hold_op(a, b, 2'b00, 1'b0);
        end

        // Timeout edge: last allowed edge must still complete.
        do_op((exp_cur == 2'b01) ? 2'b10 : 2'b01, LIM + 2, "R8 last_edge_ok");

        // Reserved code: ignored, sticky error.
        do_op(2'b11, 3, "R6 reserved");
        do_op((exp_cur == 2'b00) ? 2'b10 : 2'b00, 3, "R6 err_stays");

        // Clear the flag, then an answer one edge too late.
        apply_reset();
        do_op(2'b01, LIM + 3, "R8 abort_keeps_rate");
        do_op(2'b10, 3, "R8 switch_after_abort");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule